// File: doc/BRIEF.md
# Maskable Sticky Interrupt Controller

This block gathers single-cycle event pulses from video status sources, such as lock gained, lock lost, a change of detected format or a captured data packet, into a vector of sticky pending bits. Each pending bit is gated by its own enable bit. The gated bits are combined with a software force into one interrupt request. The request drives a single interrupt pin, which can be set up as open drain, as a push-pull output that is low when active, or as a push-pull output that is high when active.

Software reaches the block through a flat register port with a 2-bit address. The port has four registers: configuration, enable mask, a write-only acknowledge register and a read-only pending register. Reads are combinational from the current address. Writes take effect at the clock edge on which `regWr` is high. The bus protocol that carries these accesses sits outside the block.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: After reset, the pending bits, the enable mask and the configuration are all zero, so `irqOe` and `irqPin` are both 0 and reads of addresses 0, 1 and 3 return zero.
- R2: A 1 on `evtIn[i]` at a clock edge sets pending bit i at that edge. The bit stays set after the pulse ends. Address 3 reads the pending bits whatever the mask holds.
- R3: Writing to address 2 clears each pending bit whose data bit is 1 and leaves bits written with 0 unchanged. Address 2 always reads as zero.
- R4: If an event and the clear for the same bit occur in the same cycle, the bit ends up set.
- R5: The mask at address 1 reads back what was written. A mask bit of 1 lets its pending bit raise the request and a 0 blocks it, so the request is the OR over all bits of pending AND mask, OR the force bit.
- R6: Once the request is active, further events keep it asserted with no gap, so no second assertion edge occurs. It drops only when every enabled pending bit has been cleared or masked.
- R7: Configuration bits [1:0] set the pin mode. 00 is open drain: `irqOe` = request and `irqPin` = 0. 01 is active low: `irqOe` = 1 and `irqPin` = NOT request. 10 is active high: `irqOe` = 1 and `irqPin` = request. 11 acts like 01.
- R8: Configuration bit 2 forces the request active, with or without pending events.
- R9: Writes to address 3 change nothing. Address 0 reads back configuration bits [2:0], and its upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_EVT | Event pulses, one per source |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | 2 | Register address: 0 config, 1 mask, 2 clear, 3 pending |
| regWdata | input | NUM_EVT | Write data |
| regRdata | output | NUM_EVT | Read data for the addressed register (combinational) |
| irqPin | output | 1 | Interrupt pin level |
| irqOe | output | 1 | Interrupt pin output enable (0 = released) |

## Verification
Each event, acknowledge, mask or configuration write lands at the clock edge that samples it. Pending bits, read data and both pin outputs therefore show the result one edge after the stimulus, with no further pipeline delay. The bench applies every stimulus on a falling edge and checks it on the next falling edge. That gives exactly one rising edge between a stimulus and its check. Read data is checked one nanosecond after the address changes, because the read path has no register. For the no-gap rule, the request is checked on every cycle of a window of several cycles, not only once at the end.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CFG_W = 3;

  typedef enum logic [1:0] {
    DRV_OPEN_DRAIN = 2'b00,
    DRV_LOW_ACTIVE = 2'b01,
    DRV_HIGH_ACTIVE = 2'b10,
    DRV_ALT_LOW = 2'b11
  } drive_mode_e;

  typedef struct packed {
    logic       cfgWr;
    logic       maskWr;
    logic       clrWr;
    logic [1:0] rdSel;
  } reg_strobe_t;
endpackage

// File: rtl/irq_reg_ctrl.sv
module irq_reg_ctrl
  import irq_pkg::*;
(
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  output reg_strobe_t strb
);
  always_comb begin
    strb.cfgWr  = regWr && (regAddr == ADDR_CFG);
    strb.maskWr = regWr && (regAddr == ADDR_MASK);
    strb.clrWr  = regWr && (regAddr == ADDR_CLR);
    strb.rdSel  = regAddr;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [NUM_EVT-1:0] wData,
  input  reg_strobe_t        strb,
  output logic [NUM_EVT-1:0] rData,
  output logic               irqPin,
  output logic               irqOe
);
  logic [CFG_W-1:0]   cfgQ;
  logic [NUM_EVT-1:0] maskQ;
  logic [NUM_EVT-1:0] statusQ;
  logic               reqActive;
  drive_mode_e        driveMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      maskQ <= '0;
    end else begin
      if (strb.cfgWr)  cfgQ  <= wData[CFG_W-1:0];
      if (strb.maskWr) maskQ <= wData;
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= (statusQ[i] & ~(strb.clrWr & wData[i])) | evtIn[i];
    end
  end

  assign reqActive = (|(statusQ & maskQ)) | cfgQ[2];
  assign driveMode = drive_mode_e'(cfgQ[1:0]);

  always_comb begin
    case (driveMode)
      DRV_OPEN_DRAIN:  begin irqOe = reqActive; irqPin = 1'b0;       end
      DRV_HIGH_ACTIVE: begin irqOe = 1'b1;      irqPin = reqActive;  end
      default:         begin irqOe = 1'b1;      irqPin = ~reqActive; end
    endcase
  end

  always_comb begin
    rData = '0;
    case (strb.rdSel)
      ADDR_CFG:  rData[CFG_W-1:0] = cfgQ;
      ADDR_MASK: rData = maskQ;
      ADDR_STAT: rData = statusQ;
      default:   rData = '0;
    endcase
  end

  // R2: a pulsed event is visible in the pending bits one edge later
  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((statusQ & $past(evtIn)) == $past(evtIn)));

  // R3: an acknowledge with no colliding event clears the written bits
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrWr && ((wData & evtIn) == '0)) |=> ((statusQ & $past(wData)) == '0));

  // R2: with no acknowledge, pending bits never fall
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrWr |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R6: the request cannot drop unless a clear, mask or config write occurred
  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (reqActive && !strb.clrWr && !strb.maskWr && !strb.cfgWr) |=> reqActive);

  // R7: open drain never drives the pin high
  a_r7_open_drain_low: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[1:0] == 2'b00) |-> (irqPin == 1'b0));

  // R7: push-pull modes always enable the driver
  a_r7_push_pull_on: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[1:0] != 2'b00) |-> irqOe);
endmodule

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [NUM_EVT-1:0] regWdata,
  output logic [NUM_EVT-1:0] regRdata,
  output logic               irqPin,
  output logic               irqOe
);
  reg_strobe_t strb;

  irq_reg_ctrl u_ctrl (
    .regWr   (regWr),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irq_datapath #(.NUM_EVT(NUM_EVT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .evtIn  (evtIn),
    .wData  (regWdata),
    .strb   (strb),
    .rData  (regRdata),
    .irqPin (irqPin),
    .irqOe  (irqOe)
  );
endmodule

// File: tb/test_irq_sticky_ctrl.sv
module test_irq_sticky_ctrl;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] evtIn = '0;
  logic regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [N-1:0] regWdata = '0;
  logic [N-1:0] regRdata;
  logic irqPin, irqOe;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_sticky_ctrl #(.NUM_EVT(N)) i_irq_sticky_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqPin(irqPin), .irqOe(irqOe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    evtIn = e;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pins(input string req, input bit oe, input bit pin);
    check(req, int'(irqOe), int'(oe));
    check(req, int'(irqPin), int'(pin));
  endtask

  initial begin
    logic [N-1:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    pins("R1", 0, 0);
    rd(2'd0, d); check("R1", d, 0);
    rd(2'd1, d); check("R1", d, 0);
    rd(2'd3, d); check("R1", d, 0);

    // R2/R5/R3 sweep over every bit, masked and unmasked
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 2; m++) begin
        wr(2'd1, m ? N'(1 << i) : '0);
        rd(2'd1, d); check("R5", d, m ? (1 << i) : 0);
        pulse(N'(1 << i));
        @(negedge clk);
        rd(2'd3, d); check("R2", d, 1 << i);
        pins("R5", bit'(m), 0);
        wr(2'd2, N'(1 << i));
        rd(2'd3, d); check("R3", d, 0);
        pins("R3", 0, 0);
      end
    end

    // R3 partial clear and read of clear address
    pulse('1);
    wr(2'd2, 8'h0F);
    rd(2'd3, d); check("R3", d, 8'hF0);
    rd(2'd2, d); check("R3", d, 0);
    wr(2'd2, '1);

    // R4 event and clear collide
    pulse(8'h08);
    evtIn = 8'h08;
    wr(2'd2, 8'h08);
    evtIn = '0;
    rd(2'd3, d); check("R4", d, 8'h08);
    wr(2'd2, 8'h08);
    rd(2'd3, d); check("R4", d, 0);

    // R6 no gap while further events arrive
    wr(2'd1, '1);
    pulse(8'h01);
    pins("R6", 1, 0);
    for (int c = 0; c < 4; c++) begin
      evtIn = N'(1 << (c + 1));
      @(negedge clk);
      check("R6", int'(irqOe), 1);
    end
    evtIn = '0;
    wr(2'd2, 8'h01);
    pins("R6", 1, 0);
    wr(2'd1, 8'h01);
    pins("R6", 0, 0);
    wr(2'd2, '1);
    wr(2'd1, '0);

    // R7/R8 drive modes with manual force
    for (int md = 0; md < 4; md++) begin
      for (int f = 0; f < 2; f++) begin
        bit expOe, expPin;
        wr(2'd0, N'((f << 2) | md));
        expOe  = (md == 0) ? bit'(f) : 1'b1;
        expPin = (md == 0) ? 1'b0 : (md == 2) ? bit'(f) : ~bit'(f);
        pins(f ? "R8" : "R7", expOe, expPin);
      end
    end

    // R8 force with a masked pending event, R7 active high with real event
    wr(2'd0, 8'h02);
    pulse(8'h40);
    pins("R8", 1, 0);
    wr(2'd0, 8'h06);
    pins("R8", 1, 1);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h40);
    pins("R7", 1, 1);
    wr(2'd2, 8'h40);
    pins("R7", 1, 0);

    // R9 read-only pending, config readback width
    wr(2'd3, 8'hAA);
    rd(2'd3, d); check("R9", d, 0);
    pins("R9", 1, 0);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R9", d, 8'h07);
    rd(2'd1, d); check("R9", d, 8'h40);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule